// File: doc/BRIEF.md
# Chroma Subcarrier Phase-Error Serial Loader

This block retunes a chroma subcarrier oscillator while it runs. A single serial wire carries correction frames. Each frame holds a 32-bit frequency tuning word and a 12-bit phase offset. The block stores both words and applies them together to a 32-bit phase accumulator. The accumulator's top 12 bits, plus the phase offset, give the phase output. A sine lookup stage downstream uses that output.

A control-register enable bit gates the loader. While the enable is low, the serial wire is ignored and the accumulator free-runs on a built-in default frequency word. Which default is used depends on the pixel-clock mode select.

Once enabled, the receiver moves through these states:

- **OFF**: the enable is low.
- **HUNT**: the receiver counts consecutive low samples until it has seen 128 of them.
- **ARMED**: the receiver waits for a start code.
- **GOT1** and **GOT10**: the first and second start-code bits have arrived.
- **FREQ** and **PHASE**: the receiver shifts in the two words, least-significant bit first.
- **COMMIT**: one cycle in which the new words are latched.

The transitions are:

- `OFF→HUNT` on enable.
- `HUNT→ARMED` on the 128th consecutive low sample.
- `ARMED→GOT1` on a high sample.
- `GOT1→GOT10` on a low sample, and `GOT1→HUNT` on a high sample.
- `GOT10→FREQ` on a high sample, and `GOT10→HUNT` on a low sample.
- `FREQ→PHASE` after 32 bits.
- `PHASE→COMMIT` after 12 bits.
- `COMMIT→ARMED` unconditionally.
- Any state goes to OFF when the enable is low.

Top module: `sc_phase_loader`

## Requirements
- R1: After reset the accumulator is zero, `phase_out` is 0 and no loaded tuning is active.
- R2: While `loader_en` is 0, `ser_in` has no effect. On every clock the accumulator advances by the default word: 0x43E0F7AD when `sq_pixel`=0 and 0x4AAAAA0B when `sq_pixel`=1.
- R3: After `loader_en` rises, the receiver enters HUNT on the first clock. It needs 128 consecutive low samples on `ser_in` before it accepts a start code. Any high sample in HUNT restarts the count, and the counter saturates at 128. A start code that arrives after only 127 low samples is rejected.
- R4: A frame is the sample sequence 1, 0, 1. It is followed by 32 frequency bits, least-significant bit first, and then 12 phase bits, least-significant bit first.
- R5: The frequency and phase words take effect together on the clock edge after the edge that samples the last phase bit. `phase_out` shows the new offset from that edge onward. The accumulator first adds the new frequency word on the following edge.
- R6: `phase_out` equals accumulator bits 31:20 plus the active phase word, modulo 4096. The active phase word is 0 when no tuning is loaded.
- R7: A broken start pattern (1,1 or 1,0,0) returns the receiver to HUNT without changing the active tuning. A new frame is then accepted only after another 128 low samples.
- R8: After COMMIT the receiver returns to ARMED, so the next frame needs no new idle period.
- R9: When `loader_en` is sampled low, a partial frame is discarded and the default tuning is restored at that edge. Re-enabling requires the idle period again.
- R10: While loaded tuning is active, `sq_pixel` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial phase-error stream |
| loader_en | input | 1 | Control-register enable for the loader |
| sq_pixel | input | 1 | Default-word select: 0 rec-601 mode, 1 square-pixel mode |
| phase_out | output | 12 | Subcarrier phase: top accumulator bits plus phase word |

## Verification
Some properties are checked on every clock:
- A low enable forces OFF and clears the loaded tuning by the next edge.
- COMMIT always leads to ARMED and latches exactly the shifted words.
- ARMED is entered from HUNT only when the idle count is at its last step.
- The idle counter never exceeds its saturation value.
- A second high bit in GOT1 always returns the receiver to HUNT.

Other behaviour is visible only to the bench's scenarios, which compare `phase_out` with an independent accumulator model:
- the exact frame bit order;
- the rejection boundary between 127 and 128 idle samples;
- that a high sample restarts the idle count;
- that rejected or broken frames leave the tuning unchanged;
- the effect of the mode select in each condition.

// File: rtl/sc_pe_pkg.sv
package sc_pe_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_HUNT,
        ST_ARMED,
        ST_GOT1,
        ST_GOT10,
        ST_FREQ,
        ST_PHASE,
        ST_COMMIT
    } pe_state_t;

endpackage

// File: rtl/pe_idle_counter.sv
module pe_idle_counter #(
    parameter int IDLE_MIN = 128,
    localparam int CNT_W = $clog2(IDLE_MIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             met_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!count_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_W'(IDLE_MIN)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        cnt_o = cnt_q;
        met_o = count_i && (cnt_q == CNT_W'(IDLE_MIN - 1));
    end

    // R3
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(IDLE_MIN));

endmodule

// File: rtl/pe_frame_fsm.sv
module pe_frame_fsm
    import sc_pe_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12,
    localparam int BIT_W = $clog2(ACC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             ser_i,
    input  logic             idle_met_i,
    output pe_state_t        state_o,
    output logic             hunt_count_o,
    output logic             commit_o,
    output logic [ACC_W-1:0] freq_word_o,
    output logic [PH_W-1:0]  phase_word_o
);

    pe_state_t        state_q, state_d;
    logic [BIT_W-1:0] bit_q;
    logic [ACC_W-1:0] freq_sh_q;
    logic [PH_W-1:0]  phase_sh_q;
    logic             freq_last, phase_last;

    always_comb begin
        freq_last  = (bit_q == BIT_W'(ACC_W - 1));
        phase_last = (bit_q == BIT_W'(PH_W - 1));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_HUNT;
                ST_HUNT:   if (idle_met_i) state_d = ST_ARMED;
                ST_ARMED:  if (ser_i) state_d = ST_GOT1;
                ST_GOT1:   state_d = ser_i ? ST_HUNT : ST_GOT10;
                ST_GOT10:  state_d = ser_i ? ST_FREQ : ST_HUNT;
                ST_FREQ:   if (freq_last) state_d = ST_PHASE;
                ST_PHASE:  if (phase_last) state_d = ST_COMMIT;
                ST_COMMIT: state_d = ST_ARMED;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // bit counter and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q      <= '0;
            freq_sh_q  <= '0;
            phase_sh_q <= '0;
        end else begin
            if (state_q == ST_FREQ) begin
                freq_sh_q <= {ser_i, freq_sh_q[ACC_W-1:1]};
                bit_q     <= freq_last ? '0 : bit_q + 1'b1;
            end else if (state_q == ST_PHASE) begin
                phase_sh_q <= {ser_i, phase_sh_q[PH_W-1:1]};
                bit_q      <= phase_last ? '0 : bit_q + 1'b1;
            end else begin
                bit_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        state_o      = state_q;
        hunt_count_o = (state_q == ST_HUNT) && !ser_i;
        commit_o     = (state_q == ST_COMMIT);
        freq_word_o  = freq_sh_q;
        phase_word_o = phase_sh_q;
    end

    // R9
    off_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> state_q == ST_OFF);

    // R8
    commit_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && en_i) |=> state_q == ST_ARMED);

    // R7
    broken_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GOT1 && ser_i && en_i) |=> state_q == ST_HUNT);

    // R4
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PHASE) |-> bit_q < BIT_W'(PH_W));

endmodule

// File: rtl/pe_tuning_store.sv
module pe_tuning_store #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12,
    parameter logic [ACC_W-1:0] DFLT_601 = 32'h43E0F7AD,
    parameter logic [ACC_W-1:0] DFLT_SQ  = 32'h4AAAAA0B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sq_i,
    input  logic             commit_i,
    input  logic [ACC_W-1:0] freq_new_i,
    input  logic [PH_W-1:0]  phase_new_i,
    output logic [ACC_W-1:0] freq_o,
    output logic [PH_W-1:0]  phase_o
);

    logic             loaded_q;
    logic [ACC_W-1:0] freq_q;
    logic [PH_W-1:0]  phase_q;
    logic [ACC_W-1:0] dflt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
            freq_q   <= '0;
            phase_q  <= '0;
        end else if (!en_i) begin
            loaded_q <= 1'b0;
        end else if (commit_i) begin
            loaded_q <= 1'b1;
            freq_q   <= freq_new_i;
            phase_q  <= phase_new_i;
        end
    end

    always_comb begin
        dflt    = sq_i ? DFLT_SQ : DFLT_601;
        freq_o  = loaded_q ? freq_q : dflt;
        phase_o = loaded_q ? phase_q : '0;
    end

    // R5
    commit_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && en_i) |=> (loaded_q && freq_q == $past(freq_new_i)
                                && phase_q == $past(phase_new_i)));

    // R9
    drop_tuning_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !loaded_q);

endmodule

// File: rtl/pe_phase_accum.sv
module pe_phase_accum #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] freq_i,
    input  logic [PH_W-1:0]  phase_i,
    output logic [PH_W-1:0]  phase_o
);

    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + freq_i;
    end

    always_comb begin
        phase_o = acc_q[ACC_W-1 -: PH_W] + phase_i;
    end

endmodule

// File: rtl/sc_phase_loader.sv
module sc_phase_loader
    import sc_pe_pkg::*;
#(
    parameter int ACC_W    = 32,
    parameter int PH_W     = 12,
    parameter int IDLE_MIN = 128,
    parameter logic [ACC_W-1:0] DFLT_601 = 32'h43E0F7AD,
    parameter logic [ACC_W-1:0] DFLT_SQ  = 32'h4AAAAA0B
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_in,
    input  logic            loader_en,
    input  logic            sq_pixel,
    output logic [PH_W-1:0] phase_out
);

    localparam int CNT_W = $clog2(IDLE_MIN + 1);

    pe_state_t        fsm_state;
    logic             hunt_count, idle_met, commit;
    logic [CNT_W-1:0] idle_cnt;
    logic [ACC_W-1:0] freq_shift, freq_act;
    logic [PH_W-1:0]  phase_shift, phase_act;

    pe_idle_counter #(.IDLE_MIN(IDLE_MIN)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (hunt_count),
        .cnt_o   (idle_cnt),
        .met_o   (idle_met)
    );

    pe_frame_fsm #(.ACC_W(ACC_W), .PH_W(PH_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (loader_en),
        .ser_i        (ser_in),
        .idle_met_i   (idle_met),
        .state_o      (fsm_state),
        .hunt_count_o (hunt_count),
        .commit_o     (commit),
        .freq_word_o  (freq_shift),
        .phase_word_o (phase_shift)
    );

    pe_tuning_store #(
        .ACC_W(ACC_W), .PH_W(PH_W), .DFLT_601(DFLT_601), .DFLT_SQ(DFLT_SQ)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (loader_en),
        .sq_i        (sq_pixel),
        .commit_i    (commit),
        .freq_new_i  (freq_shift),
        .phase_new_i (phase_shift),
        .freq_o      (freq_act),
        .phase_o     (phase_act)
    );

    pe_phase_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .freq_i  (freq_act),
        .phase_i (phase_act),
        .phase_o (phase_out)
    );

    // R3
    arm_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_ARMED && $past(fsm_state) == ST_HUNT)
            |-> $past(idle_cnt) == CNT_W'(IDLE_MIN - 1));

endmodule

// File: tb/sim_sc_phase_loader.sv
module sim_sc_phase_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0;
    logic        loader_en = 1'b0;
    logic        sq_pixel = 1'b0;
    logic [11:0] phase_out;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    // bench model of the accumulator, written from the requirements
    logic [31:0] m_acc;
    logic        m_loaded = 1'b0;
    logic [31:0] m_f = '0;
    logic [11:0] m_p = '0;
    logic        m_sq = 1'b0;
    logic [31:0] m_step;

    always #10 clk = ~clk;

    sc_phase_loader u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .loader_en (loader_en),
        .sq_pixel  (sq_pixel),
        .phase_out (phase_out)
    );

    always_comb m_step = m_loaded ? m_f : (m_sq ? 32'h4AAAAA0B : 32'h43E0F7AD);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_acc <= '0;
        else        m_acc <= m_acc + m_step;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag);
        logic [11:0] exp;
        exp = m_acc[31:20] + (m_loaded ? m_p : 12'd0);
        n_chk = n_chk + 1;
        if (phase_out !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: phase_out actual %h expected %h", tag, phase_out, exp);
        end
    endtask

    task automatic run_chk(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag);
        end
    endtask

    task automatic drive(input logic b);
        @(negedge clk);
        ser_in = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0);
    endtask

    task automatic enable_idle(input int n);
        @(negedge clk);
        loader_en = 1'b1;
        ser_in    = 1'b0;
        idle(n);
    endtask

    task automatic disable_ld(input string tag);
        @(negedge clk);
        loader_en = 1'b0;
        ser_in    = 1'b0;
        @(negedge clk);
        m_loaded = 1'b0;
        chk(tag);
    endtask

    task automatic send_bits(input logic [31:0] f, input logic [11:0] p);
        for (int i = 0; i < 32; i++) drive(f[i]);
        for (int i = 0; i < 12; i++) drive(p[i]);
    endtask

    task automatic send_frame(input logic [31:0] f, input logic [11:0] p,
                              input bit accept, input string tag);
        drive(1'b1); drive(1'b0); drive(1'b1);
        send_bits(f, p);
        drive(1'b0);
        @(negedge clk);
        if (accept) begin
            m_loaded = 1'b1;
            m_f = f;
            m_p = p;
        end
        chk(tag);
    endtask

    // scenarios
    task automatic t_reset;
        #5 chk("R1");
        repeat (3) @(negedge clk);
        chk("R1");
        rst_n = 1'b1;
        run_chk(5, "R1");
    endtask

    task automatic t_disabled;
        send_frame(32'h12345678, 12'hABC, 1'b0, "R2");
        run_chk(6, "R2");
        @(negedge clk);
        sq_pixel = 1'b1;
        m_sq     = 1'b1;
        run_chk(6, "R2");
        @(negedge clk);
        sq_pixel = 1'b0;
        m_sq     = 1'b0;
        run_chk(3, "R2");
    endtask

    task automatic t_load;
        enable_idle(128);
        send_frame(32'h0137F00D, 12'h5A3, 1'b1, "R5");
        run_chk(20, "R6");
        send_frame(32'h80000001, 12'hFFF, 1'b1, "R8");
        run_chk(20, "R4");
    endtask

    task automatic t_sq_loaded;
        @(negedge clk);
        sq_pixel = 1'b1;
        m_sq     = 1'b1;
        run_chk(8, "R10");
        @(negedge clk);
        sq_pixel = 1'b0;
        m_sq     = 1'b0;
    endtask

    task automatic t_broken;
        drive(1'b1); drive(1'b1);
        send_bits(32'h00FF00FF, 12'h0F0);
        run_chk(4, "R7");
        send_frame(32'h11111111, 12'h111, 1'b0, "R7");
        drive(1'b1); drive(1'b0); drive(1'b0);
        send_frame(32'h22222222, 12'h222, 1'b0, "R7");
        idle(128);
        send_frame(32'h0ABCDEF1, 12'h3C4, 1'b1, "R7");
        run_chk(5, "R7");
    endtask

    task automatic t_idle_bound;
        disable_ld("R9");
        enable_idle(127);
        send_frame(32'h7FFF0000, 12'h801, 1'b0, "R3");
        disable_ld("R9");
        enable_idle(100);
        drive(1'b1);
        idle(60);
        send_frame(32'h33333333, 12'h333, 1'b0, "R3");
        disable_ld("R9");
        enable_idle(100);
        drive(1'b1);
        idle(128);
        send_frame(32'h00400000, 12'h010, 1'b1, "R3");
        run_chk(8, "R3");
    endtask

    task automatic t_abort;
        drive(1'b1); drive(1'b0); drive(1'b1);
        for (int i = 0; i < 10; i++) drive(1'b1);
        disable_ld("R9");
        run_chk(4, "R9");
        enable_idle(0);
        send_frame(32'h44444444, 12'h444, 1'b0, "R9");
        run_chk(4, "R9");
        disable_ld("R9");
        @(negedge clk);
        sq_pixel = 1'b1;
        m_sq     = 1'b1;
        run_chk(4, "R2");
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_load();
        t_sq_loaded();
        t_broken();
        t_idle_bound();
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule